// File: doc/BRIEF.md
# Shared System Counter with Per-Core Compare Timers

This block keeps one free-running count that advances by one at a fixed rate, set by a clock prescaler. Every timer channel sees the same count value, so all cores share one timebase. Each core owns two channels. The physical channel compares the raw count against its compare register. The virtual channel compares the count minus a shared offset register, with the subtraction taken modulo 2^CNT_W.

Software uses a single-cycle register port to program offsets, compare values and per-channel control bits. It can also read the count back for timestamps. A channel's status is set when it is enabled and its selected count has reached the compare value. Its interrupt line is that status gated by a mask bit, and it stays high until software disables the channel, masks it, or moves the compare value forward.

Channel `c` belongs to core `c/2`. Bit 0 of `c` selects the comparison: 0 means physical and 1 means virtual.

Top module: `systimer_bank`

## Requirements
- R1: While reset is held, the count, the offset, every compare value and every control bit read as zero, and all interrupt lines are low.
- R2: The count rises by exactly one every PRESCALE clock cycles. After 2^CNT_W-1 it wraps to 0.
- R3: Reading address 0 returns the current count. The read path is combinational from `rd_addr_i` to `rd_data_o`.
- R4: The status of a physical channel (even `c`) is 1 exactly when its enable bit is set and count >= compare, using an unsigned comparison.
- R5: A virtual channel (odd `c`) applies the rule of R4 to (count - offset) mod 2^CNT_W. The offset is one shared register at address 1.
- R6: `irq_o[c]` equals status AND NOT mask. It stays high with no further stimulus, and it drops once the channel is disabled, masked, or given a compare value above the selected count.
- R7: The status bit keeps showing the met condition while the channel's mask is set.
- R8: If a channel is already enabled and unmasked, writing a compare value at or below its selected count drives its interrupt high in the cycle right after the write.
- R9: Writes to address 0 are ignored. The count keeps its normal progression.
- R10: Physical channels of different cores that hold the same compare value raise their interrupts in the same cycle.
- R11: The register map is as follows. Compare of channel `c` is at 2+2c. Control of channel `c` is at 3+2c, with enable at bit 0, mask at bit 1 and read-only status at bit 2. A write to bit 2 has no effect. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | CNT_W | Write data |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | CNT_W | Read data for `rd_addr_i` (combinational) |
| irq_o | output | 2*N_CORES | Level interrupt per channel |

## Verification
A count that is off by one tick or stalls shows up as a wrong difference between two count reads taken a known number of cycles apart. A wrong offset or a wrong compare register shows up as a status bit or interrupt line that disagrees with the expected value in the first cycle after the write. Errors in the comparison direction or the modulo arithmetic show up where the virtual count has been pushed past zero by a large offset. The same errors show up where the count itself wraps. A latched or sticky interrupt path shows up within one cycle of a mask, disable, or forward compare write.

// File: rtl/systimer_pkg.sv
package systimer_pkg;
   localparam int ADDR_COUNT   = 0;
   localparam int ADDR_OFFSET  = 1;
   localparam int ADDR_CH_BASE = 2;
   localparam int CTL_EN_BIT   = 0;
   localparam int CTL_MASK_BIT = 1;
   localparam int CTL_STAT_BIT = 2;

   typedef enum logic {
      CH_PHYS = 1'b0,
      CH_VIRT = 1'b1
   } ch_kind_e;

   function automatic int cmp_addr(input int ch);
      return ADDR_CH_BASE + 2 * ch;
   endfunction

   function automatic int ctl_addr(input int ch);
      return ADDR_CH_BASE + 2 * ch + 1;
   endfunction
endpackage

// File: rtl/systimer_counter.sv
module systimer_counter #(
   parameter int CNT_W    = 64,
   parameter int PRESCALE = 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   output logic [CNT_W-1:0] cnt_o
);
   logic             tick_w;
   logic [CNT_W-1:0] cnt_q;

   generate
      if (PRESCALE == 1) begin : g_direct
         assign tick_w = 1'b1;
      end else begin : g_divided
         localparam int DIV_W = $clog2(PRESCALE);
         logic [DIV_W-1:0] div_q;
         assign tick_w = (div_q == DIV_W'(PRESCALE - 1));
         always_ff @(posedge clk_i) begin
            if (!rst_ni)     div_q <= '0;
            else if (tick_w) div_q <= '0;
            else             div_q <= div_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (tick_w) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt_o = cnt_q;

   // R2
   cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_w |=> cnt_q == $past(cnt_q) + CNT_W'(1));

   // R2
   cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_w |=> $stable(cnt_q));
endmodule

// File: rtl/systimer_channel.sv
module systimer_channel #(
   parameter int CNT_W = 64
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] sel_cnt_i,
   input  logic             base_chg_i,
   input  logic             wr_cmp_i,
   input  logic             wr_ctl_i,
   input  logic [CNT_W-1:0] wr_data_i,
   output logic [CNT_W-1:0] cmp_o,
   output logic             en_o,
   output logic             mask_o,
   output logic             status_o,
   output logic             irq_o
);
   import systimer_pkg::*;

   logic [CNT_W-1:0] cmp_q;
   logic             en_q;
   logic             mask_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cmp_q  <= '0;
         en_q   <= 1'b0;
         mask_q <= 1'b0;
      end else begin
         if (wr_cmp_i) cmp_q <= wr_data_i;
         if (wr_ctl_i) begin
            en_q   <= wr_data_i[CTL_EN_BIT];
            mask_q <= wr_data_i[CTL_MASK_BIT];
         end
      end
   end

   assign status_o = en_q && (sel_cnt_i >= cmp_q);
   assign irq_o    = status_o && !mask_q;
   assign cmp_o    = cmp_q;
   assign en_o     = en_q;
   assign mask_o   = mask_q;

   // R8
   past_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_cmp_i && !wr_ctl_i && !base_chg_i && en_q && !mask_q &&
       wr_data_i <= sel_cnt_i && sel_cnt_i != '1) |=> irq_o);

   // R6
   level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && !wr_cmp_i && !wr_ctl_i && !base_chg_i && sel_cnt_i != '1) |=> irq_o);

   // R4
   status_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(status_o) |-> $past(wr_cmp_i || wr_ctl_i || base_chg_i || sel_cnt_i == '1));
endmodule

// File: rtl/systimer_bank.sv
module systimer_bank #(
   parameter int N_CORES  = 2,
   parameter int CNT_W    = 64,
   parameter int PRESCALE = 1,
   parameter int ADDR_W   = 4
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic                   wr_en_i,
   input  logic [ADDR_W-1:0]      wr_addr_i,
   input  logic [CNT_W-1:0]       wr_data_i,
   input  logic [ADDR_W-1:0]      rd_addr_i,
   output logic [CNT_W-1:0]       rd_data_o,
   output logic [2*N_CORES-1:0]   irq_o
);
   import systimer_pkg::*;

   localparam int NCH    = 2 * N_CORES;
   localparam int N_REGS = ADDR_CH_BASE + 2 * NCH;

   if (N_CORES < 1)           begin : g_bad_cores  $error("N_CORES must be at least 1"); end
   if (CNT_W < 3)             begin : g_bad_width  $error("CNT_W must be at least 3"); end
   if (PRESCALE < 1)          begin : g_bad_pre    $error("PRESCALE must be at least 1"); end
   if (N_REGS > (1 << ADDR_W)) begin : g_bad_addr   $error("ADDR_W too small for register map"); end

   logic [CNT_W-1:0] cnt_w;
   logic [CNT_W-1:0] off_q;
   logic [CNT_W-1:0] virt_cnt_w;
   logic             off_wr_w;

   logic [CNT_W-1:0] cmp_w [NCH];
   logic [NCH-1:0]   en_w;
   logic [NCH-1:0]   mask_w;
   logic [NCH-1:0]   status_w;

   systimer_counter #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_counter (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cnt_o  (cnt_w)
   );

   assign off_wr_w = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_OFFSET));

   always_ff @(posedge clk_i) begin
      if (!rst_ni)       off_q <= '0;
      else if (off_wr_w) off_q <= wr_data_i;
   end

   assign virt_cnt_w = cnt_w - off_q;

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         localparam ch_kind_e KIND = ch_kind_e'(c % 2);
         logic [CNT_W-1:0] sel_w;
         logic             chg_w;
         if (KIND == CH_VIRT) begin : g_virt
            assign sel_w = virt_cnt_w;
            assign chg_w = off_wr_w;
         end else begin : g_phys
            assign sel_w = cnt_w;
            assign chg_w = 1'b0;
         end
         systimer_channel #(.CNT_W(CNT_W)) u_chan (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .sel_cnt_i  (sel_w),
            .base_chg_i (chg_w),
            .wr_cmp_i   (wr_en_i && (wr_addr_i == ADDR_W'(cmp_addr(c)))),
            .wr_ctl_i   (wr_en_i && (wr_addr_i == ADDR_W'(ctl_addr(c)))),
            .wr_data_i  (wr_data_i),
            .cmp_o      (cmp_w[c]),
            .en_o       (en_w[c]),
            .mask_o     (mask_w[c]),
            .status_o   (status_w[c]),
            .irq_o      (irq_o[c])
         );
      end
   endgenerate

   always_comb begin
      rd_data_o = '0;
      if (rd_addr_i == ADDR_W'(ADDR_COUNT))  rd_data_o = cnt_w;
      if (rd_addr_i == ADDR_W'(ADDR_OFFSET)) rd_data_o = off_q;
      for (int c = 0; c < NCH; c++) begin
         if (rd_addr_i == ADDR_W'(cmp_addr(c))) rd_data_o = cmp_w[c];
         if (rd_addr_i == ADDR_W'(ctl_addr(c)))
            rd_data_o = CNT_W'({status_w[c], mask_w[c], en_w[c]});
      end
   end
endmodule

// File: tb/systimer_bank_test.sv
module systimer_bank_test;
   localparam int CLK_PERIOD = 10;
   localparam int CW  = 10;
   localparam int AW  = 4;
   localparam int NC  = 2;
   localparam int MOD = 1 << CW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [CW-1:0] rd_data;
   logic [2*NC-1:0] irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   systimer_bank #(.N_CORES(NC), .CNT_W(CW), .PRESCALE(2), .ADDR_W(AW)) uut (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
   );

   typedef struct packed {
      logic [1:0]  ch;
      logic        en;
      logic        mask;
      logic [9:0]  vtgt;
      logic [11:0] delta;
      logic        exp_st;
      logic        exp_irq;
   } vec_t;

   localparam vec_t VEC [9] = '{
      '{2'd0, 1'b1, 1'b0, 10'd0,    -12'sd5,  1'b1, 1'b1},
      '{2'd0, 1'b1, 1'b0, 10'd0,     12'sd40, 1'b0, 1'b0},
      '{2'd0, 1'b0, 1'b0, 10'd0,    -12'sd5,  1'b0, 1'b0},
      '{2'd1, 1'b1, 1'b0, 10'd500,  -12'sd3,  1'b1, 1'b1},
      '{2'd1, 1'b1, 1'b0, 10'd500,   12'sd40, 1'b0, 1'b0},
      '{2'd3, 1'b1, 1'b1, 10'd5,    -12'sd2,  1'b1, 1'b0},
      '{2'd3, 1'b1, 1'b0, 10'd1000, -12'sd10, 1'b1, 1'b1},
      '{2'd3, 1'b1, 1'b0, 10'd1000,  12'sd15, 1'b0, 1'b0},
      '{2'd2, 1'b1, 1'b1, 10'd0,     12'sd30, 1'b0, 1'b0}
   };

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = CW'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      rd_addr = AW'(a);
      #1;
      d = int'(rd_data);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int v, a, b, c;
      // R1 reset state
      repeat (3) @(negedge clk);
      rd(0, v); chk("R1 count", v, 0);
      rd(1, v); chk("R1 offset", v, 0);
      for (int ch = 0; ch < 2*NC; ch++) begin
         rd(2 + 2*ch, v); chk("R1 compare", v, 0);
         rd(3 + 2*ch, v); chk("R1 control", v, 0);
      end
      chk("R1 irq", irq, 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (40) @(negedge clk);

      // R4 R5 R7 vector table
      for (int i = 0; i < 9; i++) begin
         int cmpv, offv, ch;
         ch = int'(VEC[i].ch);
         wr(3 + 2*ch, 0);
         rd(0, c);
         if (ch % 2 == 1) begin
            offv = (c - int'(VEC[i].vtgt) + MOD) % MOD;
            cmpv = (int'(VEC[i].vtgt) + int'($signed(VEC[i].delta)) + MOD) % MOD;
            wr(1, offv);
         end else begin
            cmpv = (c + int'($signed(VEC[i].delta)) + MOD) % MOD;
         end
         wr(2 + 2*ch, cmpv);
         wr(3 + 2*ch, {VEC[i].mask, VEC[i].en});
         rd(3 + 2*ch, v);
         chk((ch % 2 == 1) ? "R5 virtual status" : "R4 physical status", (v >> 2) & 1, VEC[i].exp_st);
         chk("R7 irq vs mask", irq[ch], VEC[i].exp_irq);
      end
      for (int ch = 0; ch < 2*NC; ch++) wr(3 + 2*ch, 0);

      // R3 R2 count rate
      rd(0, a);
      repeat (20) @(negedge clk);
      rd(0, b);
      chk("R2 rate", (b - a + MOD) % MOD, 10);

      // R9 write to count ignored
      rd(0, a);
      wr(0, 700);
      rd(0, b);
      chk("R9 count write ignored", (b - a + MOD) % MOD, 1);

      // R11 register map
      wr(1, 123); rd(1, v); chk("R11 offset readback", v, 123);
      wr(6, 77);  rd(6, v); chk("R11 compare readback", v, 77);
      wr(7, 6);   rd(7, v); chk("R11 control readback", v, 2);
      rd(15, v);  chk("R11 unmapped", v, 0);
      wr(7, 0);

      // R8 R6 R7 on channel 0
      rd(0, c);
      wr(2, (c + 300) % MOD);
      wr(3, 1);
      chk("R6 future compare low", irq[0], 0);
      rd(0, c);
      wr(2, (c - 3 + MOD) % MOD);
      chk("R8 past compare fires next cycle", irq[0], 1);
      repeat (10) @(negedge clk);
      chk("R6 level held", irq[0], 1);
      wr(3, 3);
      chk("R6 masked low", irq[0], 0);
      rd(3, v); chk("R7 status while masked", (v >> 2) & 1, 1);
      wr(3, 1);
      chk("R6 unmasked high", irq[0], 1);
      rd(0, c);
      wr(2, (c + 300) % MOD);
      chk("R6 forward compare clears", irq[0], 0);
      rd(0, c);
      wr(2, (c - 1 + MOD) % MOD);
      wr(3, 0);
      chk("R6 disable clears", irq[0], 0);

      // R10 shared view
      begin
         bit mism = 1'b0;
         rd(0, c);
         wr(2, (c + 8) % MOD);
         wr(6, (c + 8) % MOD);
         wr(3, 1);
         wr(7, 1);
         for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (irq[0] !== irq[2]) mism = 1'b1;
         end
         chk("R10 same cycle", mism, 0);
         chk("R10 both fired", {irq[2], irq[0]}, 3);
      end

      // R2 wrap
      begin
         int guard = 0;
         rd(0, v);
         while (v != MOD - 1 && guard < 5000) begin
            @(negedge clk);
            rd(0, v);
            guard++;
         end
         repeat (2) @(negedge clk);
         rd(0, v);
         chk("R2 wrap to zero", v, 0);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule